// File: doc/BRIEF.md
# Two-Stage Chirp Tone Generator

This block synthesizes a digital sine wave whose frequency can sweep linearly over time. Two accumulators are cascaded. The outer one holds the phase step, called the increment. On each clock it adds a signed sweep rate to that step and keeps the result between a lower and an upper limit. The inner one adds the current step to a 32-bit phase register. That register wraps once per output period and so produces a sawtooth.

The ten most significant phase bits select a point on one sine period. A stored quarter wave of 256 magnitudes, read with mirroring and negation, turns that point into a 12-bit two's-complement sample.

A one-cycle start pulse begins a sweep. It loads the programmed start step, limited to the bounds, and clears the phase. A hold input freezes the step at its current value, so the output stays at a fixed tone while the phase keeps running. With a zero rate the block is a plain fixed-frequency synthesizer. A positive or negative rate gives rising or falling sweeps.

Top module: `chirp_dds`

## Requirements
- R1: While rst_n is low, phase, incr and sample are all zero.
- R2: When start is high at a clock edge, phase becomes 0 after that edge. incr becomes start_inc clamped to [inc_lo, inc_hi].
- R3: When start is low at a clock edge, phase becomes phase + incr modulo 2^32, using the incr value from before the edge.
- R4: When start and hold are both low, and incr + chirp_rate (chirp_rate taken as signed two's complement) lies within [inc_lo, inc_hi], incr becomes that sum.
- R5: When start and hold are low and incr + chirp_rate exceeds inc_hi, incr becomes inc_hi rather than wrapping.
- R6: When start and hold are low and incr + chirp_rate is below inc_lo, incr becomes inc_lo. A sum below zero does not wrap.
- R7: When hold is high and start is low, incr keeps its value while phase still advances.
- R8: sample equals the sine value of the phase two cycles earlier. Take a = phase[31:22], quadrant a[9:8], index a[7:0]. Odd quadrants use index 255 - a[7:0]. Quadrants 2 and 3 negate the result. The stored magnitude for index k is round(2047 * sin(pi*(k+0.5)/512)), so sample is never -2048.
- R9: start takes priority over hold: with both high, the R2 load happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sweep start pulse: load step, clear phase |
| hold | input | 1 | Freeze the phase step |
| start_inc | input | 32 | Initial phase step |
| chirp_rate | input | 32 | Signed step change per cycle |
| inc_lo | input | 32 | Lower bound of the phase step |
| inc_hi | input | 32 | Upper bound of the phase step |
| phase | output | 32 | Phase accumulator value |
| incr | output | 32 | Current phase step |
| sample | output | 12 | Signed sine sample |

## Verification
The checks assume inc_lo <= inc_hi. They also assume that both bounds change only in a cycle where start is high, because the in-range property compares the step against the bounds of the previous edge.

The stimulus picks a fresh pair of ordered bounds only together with a start pulse and keeps them constant for the rest of each segment. Rates are drawn both small and large, and both positive and negative, so that both clamps and the free ramp are reached.

// File: rtl/chirp_dds_pkg.sv
package chirp_dds_pkg;

    localparam int PH_W    = 32;
    localparam int ADDR_W  = 10;
    localparam int AMP_W   = 12;
    localparam int QTR_W   = ADDR_W - 2;
    localparam int QTR_N   = 1 << QTR_W;
    localparam int MAG_W   = AMP_W - 1;
    localparam int MAG_MAX = (1 << MAG_W) - 1;

    typedef logic [QTR_N-1:0][MAG_W-1:0] qtr_tbl_t;

    // Quarter-wave magnitudes sampled at half-step offsets, so mirroring
    // the index yields the exact symmetric point without a 257th entry.
    function automatic qtr_tbl_t build_qtr_tbl();
        qtr_tbl_t t;
        real      ang;
        for (int k = 0; k < QTR_N; k++) begin
            ang  = 3.14159265358979 * (real'(k) + 0.5) / real'(2 * QTR_N);
            t[k] = MAG_W'($rtoi(real'(MAG_MAX) * $sin(ang) + 0.5));
        end
        return t;
    endfunction

endpackage

// File: rtl/incr_stage.sv
module incr_stage
    import chirp_dds_pkg::*;
#(
    parameter int W = PH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                freeze,
    input  logic [W-1:0]        start_inc,
    input  logic signed [W-1:0] rate,
    input  logic [W-1:0]        lo,
    input  logic [W-1:0]        hi,
    output logic [W-1:0]        inc
);

    localparam int XW = W + 2;

    typedef struct packed {
        logic [W-1:0] inc;
    } inc_st_t;

    inc_st_t st_d, st_q;

    logic signed [XW-1:0] sum_x, tgt_x, lo_x, hi_x;
    logic [W-1:0]         clamped;

    always_comb begin
        sum_x = $signed({2'b00, st_q.inc}) + $signed({{2{rate[W-1]}}, rate});
        tgt_x = load ? $signed({2'b00, start_inc}) : sum_x;
        lo_x  = $signed({2'b00, lo});
        hi_x  = $signed({2'b00, hi});
        if (tgt_x > hi_x) begin
            clamped = hi;
        end else if (tgt_x < lo_x) begin
            clamped = lo;
        end else begin
            clamped = tgt_x[W-1:0];
        end
        st_d = st_q;
        if (load || !freeze) begin
            st_d.inc = clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inc = st_q.inc;

endmodule

// File: rtl/phase_stage.sv
module phase_stage
    import chirp_dds_pkg::*;
#(
    parameter int W = PH_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] inc,
    output logic [W-1:0] phase
);

    typedef struct packed {
        logic [W-1:0] acc;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = st_q.acc + inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.acc;

endmodule

// File: rtl/sine_lut.sv
module sine_lut
    import chirp_dds_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = AMP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    output logic signed [OW-1:0] sample
);

    localparam int IW = AW - 2;
    localparam int MW = OW - 1;
    localparam qtr_tbl_t TBL = build_qtr_tbl();

    typedef struct packed {
        logic [MW-1:0]        mag;
        logic                 neg;
        logic signed [OW-1:0] smp;
    } lut_st_t;

    lut_st_t st_d, st_q;

    logic [1:0]           quad;
    logic [IW-1:0]        idx;
    logic signed [OW-1:0] mag_s;

    always_comb begin
        quad  = addr[AW-1 -: 2];
        idx   = quad[0] ? ~addr[IW-1:0] : addr[IW-1:0];
        mag_s = $signed({1'b0, st_q.mag});
        st_d      = st_q;
        st_d.mag  = TBL[idx];
        st_d.neg  = quad[1];
        st_d.smp  = st_q.neg ? -mag_s : mag_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample = st_q.smp;

endmodule

// File: rtl/chirp_dds.sv
module chirp_dds
    import chirp_dds_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    hold,
    input  logic [PH_W-1:0]         start_inc,
    input  logic signed [PH_W-1:0]  chirp_rate,
    input  logic [PH_W-1:0]         inc_lo,
    input  logic [PH_W-1:0]         inc_hi,
    output logic [PH_W-1:0]         phase,
    output logic [PH_W-1:0]         incr,
    output logic signed [AMP_W-1:0] sample
);

    logic [PH_W-1:0] inc_w;
    logic [PH_W-1:0] phase_w;

    incr_stage #(.W(PH_W)) u_incr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .freeze    (hold),
        .start_inc (start_inc),
        .rate      (chirp_rate),
        .lo        (inc_lo),
        .hi        (inc_hi),
        .inc       (inc_w)
    );

    phase_stage #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .inc   (inc_w),
        .phase (phase_w)
    );

    sine_lut #(.AW(ADDR_W), .OW(AMP_W)) u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (phase_w[PH_W-1 -: ADDR_W]),
        .sample (sample)
    );

    assign phase = phase_w;
    assign incr  = inc_w;

endmodule

// File: rtl/chirp_dds_chk.sv
module chirp_dds_chk
    import chirp_dds_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    hold,
    input logic [PH_W-1:0]         start_inc,
    input logic signed [PH_W-1:0]  chirp_rate,
    input logic [PH_W-1:0]         inc_lo,
    input logic [PH_W-1:0]         inc_hi,
    input logic [PH_W-1:0]         phase,
    input logic [PH_W-1:0]         incr,
    input logic signed [AMP_W-1:0] sample
);

    logic signed [PH_W+1:0] ramp_x;
    assign ramp_x = $signed({2'b00, incr}) + $signed({{2{chirp_rate[PH_W-1]}}, chirp_rate});

    logic ramp_free;
    assign ramp_free = (ramp_x >= $signed({2'b00, inc_lo})) && (ramp_x <= $signed({2'b00, inc_hi}));

    assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!start) |-> phase == $past(phase) + $past(incr));

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> phase == '0);

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && $past(start_inc) >= $past(inc_lo) && $past(start_inc) <= $past(inc_hi))
        |-> incr == $past(start_inc));

    assert_free_ramp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!start && !hold) && $past(ramp_free))
        |-> incr == $past(ramp_x[PH_W-1:0]));

    assert_incr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!start && !hold) |-> (incr >= $past(inc_lo) && incr <= $past(inc_hi)));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold && !start) |-> $stable(incr));

    assert_no_min_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample != $signed({1'b1, {(AMP_W-1){1'b0}}}));

endmodule

bind chirp_dds chirp_dds_chk u_chk (.*);

// File: tb/chirp_dds_tb.sv
module chirp_dds_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        hold = 1'b0;
    logic [31:0] start_inc = '0;
    logic signed [31:0] chirp_rate = '0;
    logic [31:0] inc_lo = '0;
    logic [31:0] inc_hi = '0;
    logic [31:0] phase;
    logic [31:0] incr;
    logic signed [11:0] sample;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_ph = '0;
    logic [31:0] m_inc = '0;
    logic signed [11:0] m_s1 = '0;
    logic signed [11:0] m_smp = '0;
    string t_ph, t_inc;

    always #2 clk = ~clk;

    chirp_dds u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hold(hold),
        .start_inc(start_inc), .chirp_rate(chirp_rate),
        .inc_lo(inc_lo), .inc_hi(inc_hi),
        .phase(phase), .incr(incr), .sample(sample)
    );

    function automatic logic signed [11:0] sine_of(input logic [31:0] p);
        logic [9:0] a;
        int k, m;
        a = p[31:22];
        k = a[8] ? 255 - int'(a[7:0]) : int'(a[7:0]);
        m = $rtoi(2047.0 * $sin(3.14159265358979 * (real'(k) + 0.5) / 512.0) + 0.5);
        return a[9] ? 12'(-m) : 12'(m);
    endfunction

    function automatic logic [31:0] limit(input longint v, input logic [31:0] lo, input logic [31:0] hi);
        if (v > longint'(hi)) return hi;
        if (v < longint'(lo)) return lo;
        return v[31:0];
    endfunction

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, check at the next falling edge.
    task automatic cycle(input logic st, input logic hd);
        longint s;
        logic [31:0] old_inc;
        start = st;
        hold  = hd;
        old_inc = m_inc;
        m_smp = m_s1;
        m_s1  = sine_of(m_ph);
        if (st) begin
            m_inc = limit(longint'(start_inc), inc_lo, inc_hi);
            t_inc = hd ? "R9" : "R2";
            m_ph  = '0;
            t_ph  = hd ? "R9" : "R2";
        end else begin
            m_ph = m_ph + old_inc;
            t_ph = hd ? "R7" : "R3";
            if (hd) begin
                t_inc = "R7";
            end else begin
                s = longint'(m_inc) + longint'(chirp_rate);
                if (s > longint'(inc_hi))      t_inc = "R5";
                else if (s < longint'(inc_lo)) t_inc = "R6";
                else                           t_inc = "R4";
                m_inc = limit(s, inc_lo, inc_hi);
            end
        end
        @(negedge clk);
        check(t_ph, "phase", longint'(phase), longint'(m_ph));
        check(t_inc, "incr", longint'(incr), longint'(m_inc));
        check("R8", "sample", longint'(sample), longint'(m_smp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        start_inc  = 32'h0123_4567;
        chirp_rate = 32'sd99;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "phase", longint'(phase), 0);
        check("R1", "incr", longint'(incr), 0);
        check("R1", "sample", longint'(sample), 0);
        start_inc = '0; chirp_rate = '0;
        rst_n = 1'b1;

        // Directed: ramp into the upper clamp (R4, R5)
        inc_lo = 32'd0; inc_hi = 32'd5000; start_inc = 32'd1000; chirp_rate = 32'sd300;
        cycle(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0);
        // Falling sweep below zero clamps at the lower bound (R6)
        chirp_rate = -32'sd2000;
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0);
        // Hold keeps the step while phase advances (R7)
        chirp_rate = 32'sd777;
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1);
        // Start above the upper bound is clamped (R2); start with hold (R9)
        inc_lo = 32'd100; inc_hi = 32'd200; start_inc = 32'd9999;
        cycle(1'b1, 1'b0);
        start_inc = 32'd5;
        cycle(1'b1, 1'b1);
        cycle(1'b0, 1'b0);
        // Large step to wrap phase quickly through all quadrants (R3, R8)
        inc_lo = 32'd0; inc_hi = 32'hFFFF_FFFF; start_inc = 32'h2345_6789; chirp_rate = 32'sd0;
        cycle(1'b1, 1'b0);
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0);

        // Random segments; bounds change only with a start pulse
        for (int seg = 0; seg < 30; seg++) begin
            inc_lo    = $urandom >> 2;
            inc_hi    = inc_lo + ($urandom >> 2);
            start_inc = $urandom;
            cycle(1'b1, ($urandom % 4) == 0);
            for (int i = 0; i < 200; i++) begin
                if (($urandom % 16) == 0) begin
                    chirp_rate = ($urandom % 2) ? $signed($urandom >> 3) : -$signed($urandom >> 3);
                end else if (($urandom % 8) == 0) begin
                    chirp_rate = $signed(32'($urandom % 4096)) - 32'sd2048;
                end
                cycle(1'b0, ($urandom % 8) == 0);
            end
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule